// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt pins, each of which may be driven by logic in another clock domain. Each pin is brought into the core clock domain through a two-flop synchroniser. It is then tested against a per-pin detection mode: falling edge, rising edge, low level, high level or both edges. A detected event latches a pending flag.

The processor controls the block through a small register bus. Writes are single-cycle and reads are combinational. Through this bus it sets the detection modes and per-pin priority fields, reads and clears pending flags, and masks or unmasks pins through two separate write-only registers. The per-pin and bit layouts place pin 0 at the most significant end.

Each pin drives its own interrupt output. That output is high when the pin's flag is pending, the pin is unmasked and its priority field is nonzero. A combined output is the OR of all per-pin outputs.

Top module: `xpin_irq_ctrl`

## Requirements
- R1: After reset every pending flag is clear, every mask bit is set, every priority and mode field is 0, every register reads as 0 and all interrupt outputs are low.
- R2: A change on a pin sets its pending flag on the third rising clock edge after the change, and not on the second.
- R3: Mode code 0 sets pending only on a falling edge, code 1 only on a rising edge, and code 4 on either edge.
- R4: Mode code 2 sets pending while the pin is low, and code 3 while it is high. A clear written while the level is still present leaves the flag set, because a set in the same cycle wins over a clear.
- R5: Pending register (address 2): pin n is at bit FLAG_W-1-n. Writing 0 to that bit clears the flag, and writing 1 leaves it unchanged.
- R6: Mask-set register (address 3): writing 1 at bit FLAG_W-1-n masks pin n. Bits written as 0 change nothing, and the register reads as 0.
- R7: Mask-clear register (address 4): writing 1 at bit FLAG_W-1-n unmasks pin n. Bits written as 0 change nothing, and the register reads as 0.
- R8: Priority register (address 1): a 4-bit field for pin n at bits (7-n)*4 upward, which reads back as written. A zero field holds the pin's output low, and any nonzero value lets it through.
- R9: Mode register (address 0): a SENSE_W-bit field for pin n at bits (7-n)*SENSE_W upward, which reads back as written. Codes 5 and above detect nothing.
- R10: irq_o[n] is high exactly when pin n is pending, unmasked and has a nonzero priority, and irq_any_o is their OR. Masking does not stop a flag from being latched, so the flag reaches the output once the pin is unmasked.
- R11: Addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | External interrupt pins (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | NUM_PINS | Per-pin interrupt outputs |
| irq_any_o | output | 1 | OR of all per-pin outputs |

## Verification
The hardest case to reach from the ports is a pending clear that arrives while a pin is still asserting a level or producing an edge in the same cycle. The synchroniser hides the pin by three clock edges, so the bench has to time the write against a pin change made several cycles earlier. Directed steps cover the held-level case and the exact latency. A long random phase then toggles pins and issues writes independently and at a high rate, so that clears, mask writes and mode changes land in every phase of the synchroniser pipeline. A cycle model of the requirements checks each of these collisions.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

    localparam int MAX_PINS = 8;
    localparam int PRIO_W   = 4;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_SENSE = 3'd0,
        REG_PRIO  = 3'd1,
        REG_PEND  = 3'd2,
        REG_MSET  = 3'd3,
        REG_MCLR  = 3'd4
    } reg_sel_e;

    typedef enum logic [3:0] {
        DET_FALL = 4'd0,
        DET_RISE = 4'd1,
        DET_LOW  = 4'd2,
        DET_HIGH = 4'd3,
        DET_BOTH = 4'd4
    } det_mode_e;

    // lowest bit of pin's field in a word laid out with pin 0 on top
    function automatic int field_lsb(input int pin, input int w);
        return (MAX_PINS - 1 - pin) * w;
    endfunction

    // bit of pin in a one-bit-per-pin register of width fw
    function automatic int flag_pos(input int pin, input int fw);
        return fw - 1 - pin;
    endfunction

endpackage

// File: rtl/xpin_edge_unit.sv
module xpin_edge_unit
    import xpin_pkg::*;
#(
    parameter int SENSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [SENSE_W-1:0] mode_i,
    output logic               hit_o
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } pipe_t;

    pipe_t      st_d;
    pipe_t      st_q;
    logic [3:0] mode_ext;

    always_comb begin
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;

        mode_ext = 4'(mode_i);
        hit_o    = 1'b0;
        case (mode_ext)
            DET_FALL: hit_o =  st_q.prev & ~st_q.sync;
            DET_RISE: hit_o = ~st_q.prev &  st_q.sync;
            DET_LOW:  hit_o = ~st_q.sync;
            DET_HIGH: hit_o =  st_q.sync;
            DET_BOTH: hit_o =  st_q.prev ^  st_q.sync;
            default:  hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/xpin_regfile.sv
module xpin_regfile
    import xpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int FLAG_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [BUS_W-1:0]                  wdata_i,
    input  logic [NUM_PINS-1:0]               hit_i,
    output logic [BUS_W-1:0]                  rdata_o,
    output logic [NUM_PINS-1:0][SENSE_W-1:0]  mode_o,
    output logic [NUM_PINS-1:0]               pend_o,
    output logic [NUM_PINS-1:0]               mask_o,
    output logic [NUM_PINS-1:0]               open_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0][SENSE_W-1:0] sense;
        logic [NUM_PINS-1:0][PRIO_W-1:0]  prio;
        logic [NUM_PINS-1:0]              pend;
        logic [NUM_PINS-1:0]              mask;
    } rf_t;

    rf_t  st_d;
    rf_t  st_q;
    logic wr_sense;
    logic wr_prio;
    logic wr_pend;
    logic wr_mset;
    logic wr_mclr;

    always_comb begin
        wr_sense = wr_i && (addr_i == REG_SENSE);
        wr_prio  = wr_i && (addr_i == REG_PRIO);
        wr_pend  = wr_i && (addr_i == REG_PEND);
        wr_mset  = wr_i && (addr_i == REG_MSET);
        wr_mclr  = wr_i && (addr_i == REG_MCLR);
    end

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (wr_sense)
                st_d.sense[n] = wdata_i[field_lsb(n, SENSE_W) +: SENSE_W];
            if (wr_prio)
                st_d.prio[n] = wdata_i[field_lsb(n, PRIO_W) +: PRIO_W];
            if (wr_mset && wdata_i[flag_pos(n, FLAG_W)])
                st_d.mask[n] = 1'b1;
            if (wr_mclr && wdata_i[flag_pos(n, FLAG_W)])
                st_d.mask[n] = 1'b0;
            // a zero clears; a new event in the same cycle wins
            st_d.pend[n] = (st_q.pend[n] & ~(wr_pend & ~wdata_i[flag_pos(n, FLAG_W)]))
                         | hit_i[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sense <= '0;
            st_q.prio  <= '0;
            st_q.pend  <= '0;
            st_q.mask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_SENSE: begin
                for (int n = 0; n < NUM_PINS; n++)
                    rdata_o[field_lsb(n, SENSE_W) +: SENSE_W] = st_q.sense[n];
            end
            REG_PRIO: begin
                for (int n = 0; n < NUM_PINS; n++)
                    rdata_o[field_lsb(n, PRIO_W) +: PRIO_W] = st_q.prio[n];
            end
            REG_PEND: begin
                for (int n = 0; n < NUM_PINS; n++)
                    rdata_o[flag_pos(n, FLAG_W)] = st_q.pend[n];
            end
            default: rdata_o = '0;
        endcase
    end

    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            mode_o[n] = st_q.sense[n];
            open_o[n] = |st_q.prio[n];
        end
        pend_o = st_q.pend;
        mask_o = st_q.mask;
    end

endmodule

// File: rtl/xpin_out_gate.sv
module xpin_out_gate #(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] pend_i,
    input  logic [NUM_PINS-1:0] mask_i,
    input  logic [NUM_PINS-1:0] open_i,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                any_o
);

    always_comb begin
        irq_o = pend_i & ~mask_i & open_i;
        any_o = |irq_o;
    end

endmodule

// File: rtl/xpin_irq_ctrl.sv
module xpin_irq_ctrl
    import xpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int FLAG_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                reg_wr_i,
    input  logic [2:0]          reg_addr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                irq_any_o
);

    logic [NUM_PINS-1:0][SENSE_W-1:0] mode_vec;
    logic [NUM_PINS-1:0]              evt_vec;
    logic [NUM_PINS-1:0]              pend_vec;
    logic [NUM_PINS-1:0]              mask_vec;
    logic [NUM_PINS-1:0]              open_vec;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        xpin_edge_unit #(
            .SENSE_W (SENSE_W)
        ) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[g]),
            .mode_i (mode_vec[g]),
            .hit_o  (evt_vec[g])
        );
    end

    xpin_regfile #(
        .NUM_PINS (NUM_PINS),
        .SENSE_W  (SENSE_W),
        .FLAG_W   (FLAG_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .hit_i   (evt_vec),
        .rdata_o (reg_rdata_o),
        .mode_o  (mode_vec),
        .pend_o  (pend_vec),
        .mask_o  (mask_vec),
        .open_o  (open_vec)
    );

    xpin_out_gate #(
        .NUM_PINS (NUM_PINS)
    ) u_gate (
        .pend_i (pend_vec),
        .mask_i (mask_vec),
        .open_i (open_vec),
        .irq_o  (irq_o),
        .any_o  (irq_any_o)
    );

endmodule

// File: rtl/xpin_irq_ctrl_chk.sv
module xpin_irq_ctrl_chk
    import xpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int FLAG_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_i,
    input logic [2:0]          addr_i,
    input logic [31:0]         wdata_i,
    input logic [NUM_PINS-1:0] irq_i,
    input logic [NUM_PINS-1:0] pend_i,
    input logic [NUM_PINS-1:0] hit_i
);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
        // R6: masking takes effect on the very next cycle
        assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == REG_MSET && wdata_i[FLAG_W-1-n]) |=> !irq_i[n]);

        // R8: a zero priority field silences the pin
        assert_prio_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == REG_PRIO &&
             wdata_i[(MAX_PINS-1-n)*PRIO_W +: PRIO_W] == 4'd0) |=> !irq_i[n]);

        // R3: a pending flag only rises after a detected event
        assert_pend_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_i[n]) |-> $past(hit_i[n]));

        // R5: writing one leaves the flag as it was
        assert_pend_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == REG_PEND && wdata_i[FLAG_W-1-n] && !hit_i[n])
            |=> $stable(pend_i[n]));

        // R5: writing zero clears when no event coincides
        assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == REG_PEND && !wdata_i[FLAG_W-1-n] && !hit_i[n])
            |=> !pend_i[n]);

        // R10: an output is never raised without a pending flag
        assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_i[n] |-> pend_i[n]);
    end

endmodule

bind xpin_irq_ctrl xpin_irq_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .FLAG_W   (FLAG_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .irq_i   (irq_o),
    .pend_i  (pend_vec),
    .hit_i   (evt_vec)
);

// File: tb/sim_xpin_irq_ctrl.sv
module sim_xpin_irq_ctrl;

    localparam int NP = 8;
    localparam int SW = 4;
    localparam int FW = 8;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins  = '0;
    logic          wr    = 1'b0;
    logic [2:0]    addr  = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] irq;
    logic          irq_any;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // requirement model state
    logic [3:0] m_sense [NP];
    logic [3:0] m_prio  [NP];
    bit         m_pend  [NP];
    bit         m_mask  [NP];
    bit         m_meta  [NP];
    bit         m_sync  [NP];
    bit         m_prev  [NP];

    always #2 clk = ~clk;

    xpin_irq_ctrl #(.NUM_PINS(NP), .SENSE_W(SW), .FLAG_W(FW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pins),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .irq_any_o   (irq_any)
    );

    function automatic bit hit_f(logic [3:0] md, bit s, bit p);
        case (md)
            4'd0: return p & ~s;
            4'd1: return ~p & s;
            4'd2: return ~s;
            4'd3: return s;
            4'd4: return p ^ s;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] a);
        logic [31:0] w = '0;
        for (int n = 0; n < NP; n++) begin
            case (a)
                3'd0: w[(7-n)*4 +: 4] = m_sense[n];
                3'd1: w[(7-n)*4 +: 4] = m_prio[n];
                3'd2: w[FW-1-n]       = m_pend[n];
                default: ;
            endcase
        end
        return w;
    endfunction

    function automatic logic [NP-1:0] exp_irq();
        logic [NP-1:0] v;
        for (int n = 0; n < NP; n++)
            v[n] = m_pend[n] && !m_mask[n] && (m_prio[n] != 4'd0);
        return v;
    endfunction

    task automatic model_reset();
        for (int n = 0; n < NP; n++) begin
            m_sense[n] = '0; m_prio[n] = '0; m_pend[n] = 0; m_mask[n] = 1;
            m_meta[n] = 0; m_sync[n] = 0; m_prev[n] = 0;
        end
    endtask

    task automatic tick();
        logic [3:0] ns [NP];
        logic [3:0] npr [NP];
        bit np [NP];
        bit nm [NP];
        for (int n = 0; n < NP; n++) begin
            bit h;
            bit clr;
            h = hit_f(m_sense[n], m_sync[n], m_prev[n]);
            clr = wr && addr == 3'd2 && !wdata[FW-1-n];
            np[n] = (m_pend[n] && !clr) || h;
            nm[n] = m_mask[n];
            if (wr && addr == 3'd3 && wdata[FW-1-n]) nm[n] = 1;
            if (wr && addr == 3'd4 && wdata[FW-1-n]) nm[n] = 0;
            ns[n]  = (wr && addr == 3'd0) ? wdata[(7-n)*4 +: 4] : m_sense[n];
            npr[n] = (wr && addr == 3'd1) ? wdata[(7-n)*4 +: 4] : m_prio[n];
        end
        @(posedge clk);
        for (int n = 0; n < NP; n++) begin
            m_prev[n] = m_sync[n]; m_sync[n] = m_meta[n]; m_meta[n] = pins[n];
            m_pend[n] = np[n]; m_mask[n] = nm[n];
            m_sense[n] = ns[n]; m_prio[n] = npr[n];
        end
        @(negedge clk);
    endtask

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0; wdata = '0; addr = '0;
    endtask

    task automatic read_chk(string req, logic [2:0] a, logic [31:0] exp);
        addr = a;
        #1;
        check_eq(req, rdata, exp);
        check_eq({req, " model"}, rdata, exp_read(a));
    endtask

    task automatic irq_chk(string req, logic [NP-1:0] exp);
        #1;
        check_eq(req, 32'(irq), 32'(exp));
        check_eq({req, " any"}, 32'(irq_any), 32'(|exp));
    endtask

    task automatic ticks(int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    initial begin
        #800000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) read_chk("R1 reset read", 3'(a), 32'h0);
        irq_chk("R1 reset irq", '0);

        bus_write(3'd1, 32'hFFFF_FFFF);
        bus_write(3'd4, 32'h0000_00FF);
        read_chk("R8 prio readback", 3'd1, 32'hFFFF_FFFF);
        bus_write(3'd1, 32'h1234_5678);
        read_chk("R8 prio placement", 3'd1, 32'h1234_5678);

        // R2 latency, pin0 rising
        bus_write(3'd0, 32'h1000_0000);
        read_chk("R9 sense readback", 3'd0, 32'h1000_0000);
        pins[0] = 1'b1;
        ticks(2);
        read_chk("R2 not yet pending", 3'd2, 32'h0);
        tick();
        read_chk("R2 pending on third edge", 3'd2, 32'h80);
        irq_chk("R10 pin0 out", 8'h01);

        // R5 clear semantics
        bus_write(3'd2, 32'hFF);
        read_chk("R5 ones keep", 3'd2, 32'h80);
        bus_write(3'd2, 32'h7F);
        read_chk("R5 zero clears", 3'd2, 32'h0);
        irq_chk("R5 out after clear", 8'h00);

        // R3 falling on pin1
        pins[1] = 1'b1; ticks(4);
        read_chk("R3 fall ignores rise", 3'd2, 32'h0);
        pins[1] = 1'b0; ticks(3);
        read_chk("R3 fall detected", 3'd2, 32'h40);
        bus_write(3'd2, 32'h0);

        // R3 both edges on pin2
        bus_write(3'd0, 32'h1040_0000);
        pins[2] = 1'b1; ticks(3);
        read_chk("R3 both rise", 3'd2, 32'h20);
        bus_write(3'd2, 32'h0);
        pins[2] = 1'b0; ticks(3);
        read_chk("R3 both fall", 3'd2, 32'h20);
        bus_write(3'd2, 32'h0);

        // R4 high level on pin3
        bus_write(3'd0, 32'h1043_0000);
        pins[3] = 1'b1; ticks(3);
        read_chk("R4 high level", 3'd2, 32'h10);
        bus_write(3'd2, 32'h0);
        read_chk("R4 set wins over clear", 3'd2, 32'h10);
        pins[3] = 1'b0; ticks(3);
        bus_write(3'd2, 32'h0);
        read_chk("R4 clear after level gone", 3'd2, 32'h0);

        // R4 low level on pin4 (pin already low)
        bus_write(3'd0, 32'h1043_2000);
        tick();
        read_chk("R4 low level", 3'd2, 32'h08);
        pins[4] = 1'b1; ticks(3);
        bus_write(3'd2, 32'h0);
        read_chk("R4 low level gone", 3'd2, 32'h0);

        // R9 unused code on pin5
        bus_write(3'd0, 32'h1043_2700);
        read_chk("R9 unused code readback", 3'd0, 32'h1043_2700);
        pins[5] = 1'b1; ticks(4);
        pins[5] = 1'b0; ticks(4);
        read_chk("R9 unused code detects nothing", 3'd2, 32'h0);

        // R6 / R7 masking on pin0
        pins[0] = 1'b0; ticks(3);
        pins[0] = 1'b1; ticks(3);
        irq_chk("R10 pin0 pending again", 8'h01);
        bus_write(3'd3, 32'h7F);
        irq_chk("R6 zero bit no effect", 8'h01);
        bus_write(3'd3, 32'h80);
        irq_chk("R6 mask set", 8'h00);
        read_chk("R10 still pending when masked", 3'd2, 32'h80);
        bus_write(3'd4, 32'h7F);
        irq_chk("R7 zero bit no effect", 8'h00);
        bus_write(3'd4, 32'h80);
        irq_chk("R7 mask clear", 8'h01);

        // R8 zero priority
        bus_write(3'd1, 32'h0234_5678);
        irq_chk("R8 zero prio blocks", 8'h00);
        bus_write(3'd1, 32'h1234_5678);
        irq_chk("R8 nonzero prio passes", 8'h01);

        // R11 unused addresses and write-only reads
        bus_write(3'd6, 32'hFFFF_FFFF);
        bus_write(3'd5, 32'h0);
        read_chk("R11 sense unchanged", 3'd0, 32'h1043_2700);
        read_chk("R11 prio unchanged", 3'd1, 32'h1234_5678);
        read_chk("R11 pend unchanged", 3'd2, 32'h80);
        read_chk("R6 mset reads zero", 3'd3, 32'h0);
        read_chk("R7 mclr reads zero", 3'd4, 32'h0);
        read_chk("R11 addr7 reads zero", 3'd7, 32'h0);
        irq_chk("R11 outputs unchanged", 8'h01);

        // random phase against the model
        for (int c = 0; c < 6000; c++) begin
            for (int n = 0; n < NP; n++)
                if ($urandom_range(0, 5) == 0) pins[n] = ~pins[n];
            wr    = ($urandom_range(0, 3) == 0);
            addr  = 3'($urandom_range(0, 7));
            wdata = $urandom();
            #1;
            check_eq("R10 random irq", 32'(irq), 32'(exp_irq()));
            check_eq("R10 random any", 32'(irq_any), 32'(|exp_irq()));
            check_eq("R5 random read", rdata, exp_read(addr));
            tick();
        end
        wr = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule